// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block performs one 8-bit arithmetic, logic, shift or bit-test operation per accepted request and returns the result together with a complete condition-flag byte. A request supplies a 4-bit operation code, two operands, the current flag byte and a 3-bit bit index. One clock edge later, the block presents the result, the new flag byte and a valid strobe. The current flag byte serves two purposes. Bit 0 is the carry or borrow input for the chained operations. Operations that leave some flags unchanged copy those bits from it.

The flag byte has a fixed layout. Bit 7 is sign, bit 6 is zero, bit 4 is half-carry, bit 2 is parity/overflow, bit 1 is subtract and bit 0 is carry. Bits 5 and 3 always read 0. Bit 2 has two meanings. Logic and shift operations write even parity into it. Add and subtract write signed overflow into it. A surrounding sequencer keeps the flag byte in its own register and feeds it back on the next request.

Top module: `alu8_flags`

## Requirements
- R1: While `rstN` is low, and after reset until the first accepted request, `outValid`, `result` and `flagsOut` are all 0.
- R2: A request with `inValid` high produces `outValid` high on the following clock edge. With `inValid` low, `outValid` is 0 and `result`/`flagsOut` keep their previous values.
- R3: Flag byte positions are: bit 7 sign, bit 6 zero, bit 4 half-carry, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. Bits 5 and 3 are always 0. Unless stated otherwise, sign copies bit 7 of the value the flags are computed from, and zero is set when that value is 0.
- R4: Code 0 (add) returns A+B. Code 1 (add with carry) returns A+B+flagsIn[0]. Half-carry is the carry out of bit 3. Bit 2 is signed overflow. Subtract is 0. Carry is the carry out of bit 7.
- R5: Code 2 (subtract) returns A-B. Code 3 (subtract with borrow) returns A-B-flagsIn[0]. Half-carry is the borrow into bit 4. Bit 2 is signed overflow. Subtract is 1. Carry is the borrow out of bit 7.
- R6: Code 4 (compare) sets every flag exactly as code 2 would, and `result` equals A.
- R7: Code 5 (AND), code 6 (OR) and code 7 (XOR) return the bitwise result. Bit 2 is 1 when the result has an even number of ones. Half-carry is 1 for AND and 0 for OR and XOR. Subtract and carry are 0.
- R8: Code 8 (rotate accumulator left circular) returns {A[6:0],A[7]}. Carry takes A[7]. Half-carry and subtract are 0. Sign, zero and bit 2 are copied from flagsIn.
- R9: Code 9 (arithmetic shift left) returns {A[6:0],0}. Code 10 (shift left, fill one) returns {A[6:0],1}. In both, carry takes A[7], bit 2 is even parity of the result, and half-carry and subtract are 0.
- R10: Code 11 (bit test) sets zero to the inverse of A[bitIdx], sets half-carry to 1 and clears subtract. Sign, bit 2 and carry are copied from flagsIn, and `result` equals A.
- R11: Codes 12 to 15 return A and return flagsIn with bits 5 and 3 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 4 | Operation code |
| opA | input | 8 | Operand A (accumulator) |
| opB | input | 8 | Operand B |
| flagsIn | input | 8 | Current flag byte |
| bitIdx | input | 3 | Bit position for bit test |
| outValid | output | 1 | Result strobe |
| result | output | 8 | Operation result |
| flagsOut | output | 8 | New flag byte |

## Verification
The hardest cases to reach are the boundaries where half-carry, overflow and carry separate from each other. Examples are 0x7F+1, where overflow and half-carry are set but carry is clear, and 0x80-1, where overflow is set without a borrow. Another such case is a chained operation with carry-in that wraps to exactly zero. Directed vectors place operands on these nibble and sign boundaries. Each is sent with flagsIn carry both set and clear, so the carry-in path and the copied flag bits are exercised. A long run of random codes, including the reserved codes, then covers the rest. A scoreboard compares every result against a reference model written from the requirements.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int OP_W   = 4;

  // Flag byte bit positions (the layout is part of the block's contract)
  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_H  = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_RLC  = 4'd8,
    OP_SLA  = 4'd9,
    OP_SL1  = 4'd10,
    OP_BIT  = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_ADDER,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_PASS
  } resSrc_e;

  typedef enum logic [1:0] {
    LG_AND,
    LG_OR,
    LG_XOR
  } logicSel_e;

  typedef enum logic [2:0] {
    FM_ARITH,
    FM_LOGIC,
    FM_SHIFT,
    FM_ROT,
    FM_BIT,
    FM_KEEP
  } flagMode_e;

  typedef struct packed {
    logic      subtract;   // invert B and carry-in for borrow arithmetic
    logic      useCarry;   // chain flagsIn carry into the adder
    resSrc_e   resSrc;     // which unit drives the result
    logicSel_e logicSel;   // bitwise function
    logic      shiftRot;   // circular rotate instead of shift
    logic      shiftFill;  // bit shifted into position 0
    logic      halfSet;    // half-carry value for logic ops
    flagMode_e flagMode;   // how the flag byte is built
  } aluCtrl_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl = '{
      subtract:  1'b0,
      useCarry:  1'b0,
      resSrc:    SRC_PASS,
      logicSel:  LG_AND,
      shiftRot:  1'b0,
      shiftFill: 1'b0,
      halfSet:   1'b0,
      flagMode:  FM_KEEP
    };
    case (opSel)
      OP_ADD: begin
        ctrl.resSrc   = SRC_ADDER;
        ctrl.flagMode = FM_ARITH;
      end
      OP_ADC: begin
        ctrl.resSrc   = SRC_ADDER;
        ctrl.useCarry = 1'b1;
        ctrl.flagMode = FM_ARITH;
      end
      OP_SUB: begin
        ctrl.resSrc   = SRC_ADDER;
        ctrl.subtract = 1'b1;
        ctrl.flagMode = FM_ARITH;
      end
      OP_SBC: begin
        ctrl.resSrc   = SRC_ADDER;
        ctrl.subtract = 1'b1;
        ctrl.useCarry = 1'b1;
        ctrl.flagMode = FM_ARITH;
      end
      OP_CMP: begin
        ctrl.resSrc   = SRC_PASS;
        ctrl.subtract = 1'b1;
        ctrl.flagMode = FM_ARITH;
      end
      OP_AND: begin
        ctrl.resSrc   = SRC_LOGIC;
        ctrl.logicSel = LG_AND;
        ctrl.halfSet  = 1'b1;
        ctrl.flagMode = FM_LOGIC;
      end
      OP_OR: begin
        ctrl.resSrc   = SRC_LOGIC;
        ctrl.logicSel = LG_OR;
        ctrl.flagMode = FM_LOGIC;
      end
      OP_XOR: begin
        ctrl.resSrc   = SRC_LOGIC;
        ctrl.logicSel = LG_XOR;
        ctrl.flagMode = FM_LOGIC;
      end
      OP_RLC: begin
        ctrl.resSrc   = SRC_SHIFT;
        ctrl.shiftRot = 1'b1;
        ctrl.flagMode = FM_ROT;
      end
      OP_SLA: begin
        ctrl.resSrc   = SRC_SHIFT;
        ctrl.flagMode = FM_SHIFT;
      end
      OP_SL1: begin
        ctrl.resSrc    = SRC_SHIFT;
        ctrl.shiftFill = 1'b1;
        ctrl.flagMode  = FM_SHIFT;
      end
      OP_BIT: begin
        ctrl.resSrc   = SRC_PASS;
        ctrl.flagMode = FM_BIT;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_datapath.sv
module alu8_datapath
  import alu8_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  aluCtrl_t           ctrl,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  input  logic [DATA_W-1:0]  flagsIn,
  input  logic [IDX_W-1:0]   bitIdx,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic [DATA_W-1:0]  flagsOut
);

  localparam int MSB = DATA_W - 1;

  // ---------------- adder / subtractor ----------------
  logic [DATA_W-1:0] bEff;
  logic              carryIn;
  logic              cEff;
  logic [NIB_W:0]    lowSum;
  logic [DATA_W:0]   fullSum;
  logic [DATA_W-1:0] addRes;
  logic              carryOut;
  logic              halfOut;
  logic              ovf;

  always_comb begin
    bEff     = ctrl.subtract ? ~opB : opB;
    carryIn  = ctrl.useCarry & flagsIn[FLG_C];
    cEff     = ctrl.subtract ? ~carryIn : carryIn;
    lowSum   = {1'b0, opA[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cEff};
    fullSum  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cEff};
    addRes   = fullSum[DATA_W-1:0];
    carryOut = fullSum[DATA_W] ^ ctrl.subtract;
    halfOut  = lowSum[NIB_W] ^ ctrl.subtract;
    ovf      = (opA[MSB] == bEff[MSB]) && (addRes[MSB] != opA[MSB]);
  end

  // ---------------- bitwise unit ----------------
  logic [DATA_W-1:0] logRes;

  always_comb begin
    case (ctrl.logicSel)
      LG_OR:   logRes = opA | opB;
      LG_XOR:  logRes = opA ^ opB;
      default: logRes = opA & opB;
    endcase
  end

  // ---------------- shifter ----------------
  logic [DATA_W-1:0] shRes;
  logic              shLsb;

  assign shLsb = ctrl.shiftRot ? opA[MSB] : ctrl.shiftFill;
  assign shRes = {opA[MSB-1:0], shLsb};

  // ---------------- bit selector ----------------
  logic [DATA_W-1:0] bitHit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bitSel
    assign bitHit[i] = (bitIdx == IDX_W'(i)) & opA[i];
  end

  // ---------------- result mux ----------------
  logic [DATA_W-1:0] nextRes;

  always_comb begin
    case (ctrl.resSrc)
      SRC_ADDER: nextRes = addRes;
      SRC_LOGIC: nextRes = logRes;
      SRC_SHIFT: nextRes = shRes;
      default:   nextRes = opA;
    endcase
  end

  // ---------------- flag builder ----------------
  logic [DATA_W-1:0] nextFlags;

  always_comb begin
    nextFlags = '0;
    case (ctrl.flagMode)
      FM_ARITH: begin
        nextFlags[FLG_S]  = addRes[MSB];
        nextFlags[FLG_Z]  = (addRes == '0);
        nextFlags[FLG_H]  = halfOut;
        nextFlags[FLG_PV] = ovf;
        nextFlags[FLG_N]  = ctrl.subtract;
        nextFlags[FLG_C]  = carryOut;
      end
      FM_LOGIC: begin
        nextFlags[FLG_S]  = logRes[MSB];
        nextFlags[FLG_Z]  = (logRes == '0);
        nextFlags[FLG_H]  = ctrl.halfSet;
        nextFlags[FLG_PV] = ~^logRes;
      end
      FM_SHIFT: begin
        nextFlags[FLG_S]  = shRes[MSB];
        nextFlags[FLG_Z]  = (shRes == '0);
        nextFlags[FLG_PV] = ~^shRes;
        nextFlags[FLG_C]  = opA[MSB];
      end
      FM_ROT: begin
        nextFlags[FLG_S]  = flagsIn[FLG_S];
        nextFlags[FLG_Z]  = flagsIn[FLG_Z];
        nextFlags[FLG_PV] = flagsIn[FLG_PV];
        nextFlags[FLG_C]  = opA[MSB];
      end
      FM_BIT: begin
        nextFlags[FLG_S]  = flagsIn[FLG_S];
        nextFlags[FLG_Z]  = ~|bitHit;
        nextFlags[FLG_H]  = 1'b1;
        nextFlags[FLG_PV] = flagsIn[FLG_PV];
        nextFlags[FLG_C]  = flagsIn[FLG_C];
      end
      default: begin
        nextFlags[FLG_S]  = flagsIn[FLG_S];
        nextFlags[FLG_Z]  = flagsIn[FLG_Z];
        nextFlags[FLG_H]  = flagsIn[FLG_H];
        nextFlags[FLG_PV] = flagsIn[FLG_PV];
        nextFlags[FLG_N]  = flagsIn[FLG_N];
        nextFlags[FLG_C]  = flagsIn[FLG_C];
      end
    endcase
  end

  // ---------------- output register ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result   <= nextRes;
        flagsOut <= nextFlags;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid && $stable(result) && $stable(flagsOut)); // R2

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !flagsOut[5] && !flagsOut[3]); // R3

  AST_ARITH_N: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(ctrl.flagMode) == FM_ARITH) |-> flagsOut[FLG_N] == $past(ctrl.subtract)); // R5

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] flagsIn,
  input  logic [IDX_W-1:0]  bitIdx,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagsOut
);

  aluCtrl_t ctrl;

  alu8_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu8_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .bitIdx   (bitIdx),
    .outValid (outValid),
    .result   (result),
    .flagsOut (flagsOut)
  );

  AST_CMP_PASSES_A: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opSel) == OP_CMP) |-> result == $past(opA)); // R6

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && ($past(opSel) == OP_AND || $past(opSel) == OP_OR || $past(opSel) == OP_XOR))
      |-> !flagsOut[FLG_C] && !flagsOut[FLG_N]); // R7

  AST_ROT_KEEPS_SZP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opSel) == OP_RLC)
      |-> flagsOut[FLG_S] == $past(flagsIn[FLG_S]) && flagsOut[FLG_Z] == $past(flagsIn[FLG_Z])
          && flagsOut[FLG_PV] == $past(flagsIn[FLG_PV])); // R8

  AST_BIT_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opSel) == OP_BIT)
      |-> flagsOut[FLG_C] == $past(flagsIn[FLG_C]) && flagsOut[FLG_H] && result == $past(opA)); // R10

  AST_SPARE_NOOP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && $past(opSel) >= 4'd12)
      |-> result == $past(opA) && flagsOut == ($past(flagsIn) & 8'hD7)); // R11

endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [3:0] opSel;
  logic [7:0] opA, opB, flagsIn;
  logic [2:0] bitIdx;
  logic       outValid;
  logic [7:0] result, flagsOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flags dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .bitIdx   (bitIdx),
    .outValid (outValid),
    .result   (result),
    .flagsOut (flagsOut)
  );

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    string      tag;
  } item_t;

  item_t sb[$];
  item_t cur;
  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;

  // Reference model, written from the requirements
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] f, input logic [2:0] idx);
    logic [7:0] r;
    logic s, z, h, pv, n, c;
    int t, ci, lo;
    r = a; s = f[7]; z = f[6]; h = f[4]; pv = f[2]; n = f[1]; c = f[0];
    ci = ((op == 4'd1 || op == 4'd3) && f[0]) ? 1 : 0;
    case (op)
      4'd0, 4'd1: begin
        t  = int'(a) + int'(b) + ci;
        r  = t[7:0];
        lo = int'(a[3:0]) + int'(b[3:0]) + ci;
        h  = (lo > 15);
        pv = (a[7] == b[7]) && (r[7] != a[7]);
        n  = 1'b0; c = (t > 255); s = r[7]; z = (r == 8'd0);
      end
      4'd2, 4'd3, 4'd4: begin
        t  = int'(a) - int'(b) - ci;
        r  = t[7:0];
        h  = int'(a[3:0]) < (int'(b[3:0]) + ci);
        pv = (a[7] != b[7]) && (r[7] != a[7]);
        n  = 1'b1; c = (t < 0); s = r[7]; z = (r == 8'd0);
        if (op == 4'd4) r = a;
      end
      4'd5, 4'd6, 4'd7: begin
        r  = (op == 4'd5) ? (a & b) : (op == 4'd6) ? (a | b) : (a ^ b);
        h  = (op == 4'd5);
        pv = ~^r; n = 1'b0; c = 1'b0; s = r[7]; z = (r == 8'd0);
      end
      4'd8: begin
        r = {a[6:0], a[7]}; c = a[7]; h = 1'b0; n = 1'b0;
      end
      4'd9, 4'd10: begin
        r = {a[6:0], (op == 4'd10)}; c = a[7]; h = 1'b0; n = 1'b0;
        pv = ~^r; s = r[7]; z = (r == 8'd0);
      end
      4'd11: begin
        z = ~a[idx]; h = 1'b1; n = 1'b0;
      end
      default: ;
    endcase
    return {r, s, z, 1'b0, h, 1'b0, pv, n, c};
  endfunction

  task automatic send(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                      input logic [7:0] f, input logic [2:0] idx, input string tag);
    item_t it;
    logic [15:0] e;
    @(negedge clk);
    opSel = op; opA = a; opB = b; flagsIn = f; bitIdx = idx; inValid = 1'b1;
    e = model(op, a, b, f, idx);
    it.res = e[15:8];
    it.flg = e[7:0];
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected outValid", {result, flagsOut}, 16'h0);
      end else begin
        cur = sb.pop_front();
        check({result, flagsOut} === {cur.res, cur.flg}, cur.tag, {result, flagsOut}, {cur.res, cur.flg});
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] hr, hf;
    rstN = 1'b0; inValid = 1'b0; opSel = '0; opA = '0; opB = '0; flagsIn = '0; bitIdx = '0;
    repeat (3) @(negedge clk);
    check({outValid, result, flagsOut} === 17'h0, "R1 during reset", {7'h0, outValid, result}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check({outValid, result, flagsOut} === 17'h0, "R1 after reset", {7'h0, outValid, result}, 16'h0);

    // R4 add / add with carry
    send(4'd0, 8'h7F, 8'h01, 8'h00, 3'd0, "R4 add overflow+half");
    send(4'd0, 8'hFF, 8'h01, 8'h00, 3'd0, "R4 add wrap zero carry");
    send(4'd0, 8'h12, 8'h34, 8'h01, 3'd0, "R4 add ignores carry in");
    send(4'd1, 8'hFF, 8'h00, 8'h01, 3'd0, "R4 adc wrap with carry in");
    send(4'd1, 8'h0E, 8'h01, 8'h01, 3'd0, "R4 adc half carry");
    send(4'd1, 8'h80, 8'h80, 8'h00, 3'd0, "R4 adc negative overflow");
    // R5 subtract / with borrow
    send(4'd2, 8'h80, 8'h01, 8'h00, 3'd0, "R5 sub overflow");
    send(4'd2, 8'h00, 8'h01, 8'h00, 3'd0, "R5 sub borrow");
    send(4'd2, 8'h10, 8'h01, 8'h01, 3'd0, "R5 sub half borrow");
    send(4'd3, 8'h01, 8'h00, 8'h01, 3'd0, "R5 sbc to zero");
    send(4'd3, 8'h00, 8'hFF, 8'h01, 3'd0, "R5 sbc borrow chain");
    // R6 compare
    send(4'd4, 8'h42, 8'h42, 8'h00, 3'd0, "R6 cmp equal");
    send(4'd4, 8'h10, 8'h20, 8'h01, 3'd0, "R6 cmp less");
    // R7 logic
    send(4'd5, 8'hF0, 8'h3C, 8'h01, 3'd0, "R7 and parity");
    send(4'd5, 8'h0F, 8'hF0, 8'hFF, 3'd0, "R7 and zero");
    send(4'd6, 8'h01, 8'h02, 8'h11, 3'd0, "R7 or");
    send(4'd7, 8'h5A, 8'h5A, 8'h01, 3'd0, "R7 xor zero");
    send(4'd7, 8'h80, 8'h00, 8'h00, 3'd0, "R7 xor odd parity");
    // R8 rotate
    send(4'd8, 8'h81, 8'h00, 8'hC4, 3'd0, "R8 rlc keeps szp");
    send(4'd8, 8'h40, 8'h00, 8'h13, 3'd0, "R8 rlc no carry");
    // R9 shifts
    send(4'd9, 8'h80, 8'h00, 8'h00, 3'd0, "R9 sla to zero");
    send(4'd9, 8'h41, 8'h00, 8'hFF, 3'd0, "R9 sla sign");
    send(4'd10, 8'h80, 8'h00, 8'h00, 3'd0, "R9 shift fill one");
    send(4'd10, 8'h7F, 8'h00, 8'h01, 3'd0, "R9 shift fill one all ones");
    // R10 bit test, every index
    for (int i = 0; i < 8; i++) begin
      send(4'd11, 8'hA5, 8'h00, (i % 2) ? 8'hFF : 8'h00, 3'(i), "R10 bit test");
    end
    // R11 spare codes
    for (int i = 12; i < 16; i++) begin
      send(4'(i), 8'h3C, 8'hFF, 8'hFF, 3'd0, "R11 spare code");
    end
    // R3 layout under random traffic
    for (int i = 0; i < 400; i++) begin
      send(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), "R3 random mix");
    end
    idle(1);
    @(negedge clk);
    // R2 hold while idle
    hr = result; hf = flagsOut;
    opSel = 4'd0; opA = 8'h11; opB = 8'h22; flagsIn = 8'hFF;
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R2 outValid low when idle", {15'h0, outValid}, 16'h0);
    check({result, flagsOut} === {hr, hf}, "R2 outputs held", {result, flagsOut}, {hr, hf});
    check(sb.size() == 0, "R2 every request answered", 16'(sb.size()), 16'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule